// File: doc/BRIEF.md
# Transmit Sample Word Unpacker

This block sits between a 64-bit word source and a two-channel DAC datapath. Each incoming word holds four 16-bit lanes that carry two consecutive A/B sample pairs in interleaved order. The block stores a few words in a small first-in first-out buffer. It pulls the 12 significant bits out of each lane and hands the downstream datapath one A/B pair per output-enabled cycle.

A single configuration input selects where the 12 bits sit inside each 16-bit lane: in the upper part or in the lower part. The block drives a stop signal back to the word source once the buffer has little room left. The threshold leaves enough headroom that a source which sees stop one cycle late still never overruns the buffer. Everything runs on one clock with a synchronous active-low reset.

Top module: `tx_pair_unpacker`

## Requirements
- R1: While reset is held and on the first cycle after it, `out_valid` is 0, `out_a` and `out_b` are 0, and `in_stop` is 0.
- R2: Lanes are mapped within a word as follows: bits 15:0 hold A of the first pair, 31:16 hold B of the first pair, 47:32 hold A of the second pair, and 63:48 hold B of the second pair. The first pair of a word is emitted before the second.
- R3: When `left_just` is 1, each emitted sample is bits 15:4 of its lane.
- R4: When `left_just` is 0, each emitted sample is bits 11:0 of its lane. The value of `left_just` at the edge where a pair is loaded governs that pair.
- R5: On each clock edge where `out_en` is 1 and a word is stored, the next pair is loaded and `out_valid` is 1 after that edge. A word leaves the buffer only after both of its pairs have been loaded.
- R6: On an edge where `out_en` is 0, `out_a`, `out_b` and `out_valid` keep their values and no pair is consumed.
- R7: On an edge where `out_en` is 1 and no word is stored, `out_valid` becomes 0 and `out_a` and `out_b` hold their last values.
- R8: `in_stop` is 1 exactly when the number of stored words is at least DEPTH-2 (room for two words or fewer). With the default DEPTH of 4, this means two or more stored words.
- R9: A source that raises `in_valid` only when `in_stop` was 0 one cycle earlier never finds the buffer full, and every such word is accepted.
- R10: A word presented while the buffer is full is discarded, and the stored words are not affected.
- R11: A word accepted at one edge can have its first pair loaded at the very next edge where `out_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| left_just | input | 1 | 1: sample taken from upper lane bits; 0: from lower lane bits |
| in_data | input | 64 | Packed word of two A/B pairs |
| in_valid | input | 1 | `in_data` is offered this cycle |
| in_stop | output | 1 | Backpressure to the word source |
| out_en | input | 1 | Downstream takes a pair this cycle |
| out_a | output | 12 | Channel A sample |
| out_b | output | 12 | Channel B sample |
| out_valid | output | 1 | `out_a` and `out_b` hold a fresh pair |

## Verification
Each fault in the internal state shows up at the ports within a few cycles:

- A phase bit that slips swaps or repeats pairs. This is visible on `out_a` and `out_b` at the next enabled edge.
- A wrong buffer count shows first on `in_stop`, one cycle after the faulty update. It shows later as lost or duplicated words once the buffer drains.
- A justification fault corrupts the very next sample.

The reference model tracks the stored words as a queue and compares `in_stop`, `out_valid` and both samples on every cycle. Any such divergence is therefore reported on the cycle it first reaches a port.

// File: rtl/tx_unpack_pkg.sv
// Package: shared types for the transmit sample word unpacker.
// Assumes: nothing beyond IEEE 1800-2017.
package tx_unpack_pkg;

    // Position of the significant bits inside a lane.
    typedef enum logic {
        JUST_LOW  = 1'b0,
        JUST_HIGH = 1'b1
    } just_e;

endpackage

// File: rtl/word_fifo.sv
// Module: word_fifo
// Stores whole input words in arrival order and presents the oldest one
// at rd_data without a read request (show-ahead).
// Assumes: push is never raised while full is high, and pop is never
// raised while empty is high (the parent gates both).
module word_fifo #(
    parameter int WORD_W = 64,
    parameter int DEPTH  = 4,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              pop,
    output logic [WORD_W-1:0] rd_data,
    output logic [CW-1:0]     count,
    output logic              full,
    output logic              empty
);

    logic [WORD_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr_q;
    logic [AW-1:0]     rd_ptr_q;
    logic [CW-1:0]     count_q;

    // Advances a pointer by one slot, wrapping at DEPTH.
    function automatic logic [AW-1:0] step_ptr(input logic [AW-1:0] p);
        if (p == AW'(DEPTH - 1)) begin
            return '0;
        end
        return p + AW'(1);
    endfunction

    // Writes the incoming word into the slot under the write pointer.
    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr_q] <= wr_data;
        end
    end

    // Moves the pointers and the occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            if (push) begin
                wr_ptr_q <= step_ptr(wr_ptr_q);
            end
            if (pop) begin
                rd_ptr_q <= step_ptr(rd_ptr_q);
            end
            case ({push, pop})
                2'b10:   count_q <= count_q + CW'(1);
                2'b01:   count_q <= count_q - CW'(1);
                default: count_q <= count_q;
            endcase
        end
    end

    // Exposes the head word and the occupancy flags.
    always_comb begin
        rd_data = mem[rd_ptr_q];
        count   = count_q;
        full    = (count_q == CW'(DEPTH));
        empty   = (count_q == '0);
    end

    // The count follows the accepted pushes and pops of the previous cycle.
    AST_COUNT_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> count_q == $past(count_q) + CW'($past(push)) - CW'($past(pop))); // R10

    // The count never rises above the capacity.
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CW'(DEPTH)); // R10

endmodule

// File: rtl/lane_justify.sv
// Module: lane_justify
// Takes the significant sample bits out of one lane, either from the top
// or from the bottom of the lane.
// Assumes: SAMP_W <= LANE_W. Purely combinational.
module lane_justify
    import tx_unpack_pkg::*;
#(
    parameter int LANE_W = 16,
    parameter int SAMP_W = 12
) (
    input  logic [LANE_W-1:0] lane,
    input  logic              left_sel,
    output logic [SAMP_W-1:0] sample
);

    just_e mode;

    // Chooses the upper or the lower bits of the lane.
    always_comb begin
        mode = just_e'(left_sel);
        if (mode == JUST_HIGH) begin
            sample = lane[LANE_W-1 -: SAMP_W];
        end else begin
            sample = lane[SAMP_W-1:0];
        end
    end

endmodule

// File: rtl/pair_sequencer.sv
// Module: pair_sequencer
// Walks through the pairs of the head word, one per enabled cycle, and
// registers each pair on the outputs. Releases the head word once its
// last pair has been loaded.
// Assumes: samples holds A,B,A,B... starting at index 0, and head_valid
// is high whenever samples reflects a stored word.
module pair_sequencer #(
    parameter int SAMP_W = 12,
    parameter int PAIRS  = 2,
    localparam int PH_W  = (PAIRS > 1) ? $clog2(PAIRS) : 1
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            out_en,
    input  logic                            head_valid,
    input  logic [2*PAIRS-1:0][SAMP_W-1:0]  samples,
    output logic                            pop,
    output logic [SAMP_W-1:0]               out_a,
    output logic [SAMP_W-1:0]               out_b,
    output logic                            out_valid
);

    logic [PH_W-1:0]   phase_q;
    logic [SAMP_W-1:0] sel_a;
    logic [SAMP_W-1:0] sel_b;
    logic              last_phase;
    logic              take;

    // Picks the pair that the current phase points at.
    always_comb begin
        sel_a = samples[0];
        sel_b = samples[1];
        for (int p = 0; p < PAIRS; p++) begin
            if (phase_q == PH_W'(p)) begin
                sel_a = samples[2*p];
                sel_b = samples[2*p+1];
            end
        end
    end

    // Decides whether a pair is taken and whether the word is finished.
    always_comb begin
        last_phase = (phase_q == PH_W'(PAIRS - 1));
        take       = out_en && head_valid;
        pop        = take && last_phase;
    end

    // Loads the output registers and advances the phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q   <= '0;
            out_a     <= '0;
            out_b     <= '0;
            out_valid <= 1'b0;
        end else if (out_en) begin
            if (head_valid) begin
                out_a     <= sel_a;
                out_b     <= sel_b;
                out_valid <= 1'b1;
                phase_q   <= last_phase ? '0 : phase_q + PH_W'(1);
            end else begin
                out_valid <= 1'b0;
            end
        end
    end

    // Outputs do not move on a disabled cycle.
    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(out_en)
        |-> $stable(out_a) && $stable(out_b) && $stable(out_valid)); // R6

    // An enabled cycle with nothing stored drops valid and keeps data.
    AST_DRAIN_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(out_en) && !$past(head_valid)
        |-> !out_valid && $stable(out_a) && $stable(out_b)); // R7

    // An enabled cycle with a stored word yields a valid pair.
    AST_VALID_ON_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(out_en) && $past(head_valid) |-> out_valid); // R5

    // A word is released only once the phase has returned to the start.
    AST_POP_RESETS_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(pop) |-> phase_q == '0); // R5

endmodule

// File: rtl/tx_pair_unpacker.sv
// Module: tx_pair_unpacker (top)
// Buffers 64-bit words holding interleaved A/B lanes, pulls the justified
// samples out of every lane and emits one A/B pair per enabled cycle.
// Raises in_stop when the buffer has room for STOP_ROOM words or fewer.
// Assumes: WORD_W is a multiple of 2*LANE_W, and DEPTH > STOP_ROOM >= 2,
// so that a source reacting one cycle late cannot overrun the buffer.
module tx_pair_unpacker #(
    parameter int WORD_W    = 64,
    parameter int LANE_W    = 16,
    parameter int SAMP_W    = 12,
    parameter int DEPTH     = 4,
    parameter int STOP_ROOM = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              left_just,
    input  logic [WORD_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_stop,
    input  logic              out_en,
    output logic [SAMP_W-1:0] out_a,
    output logic [SAMP_W-1:0] out_b,
    output logic              out_valid
);

    localparam int LANES = WORD_W / LANE_W;
    localparam int PAIRS = LANES / 2;
    localparam int CW    = $clog2(DEPTH + 1);

    logic [WORD_W-1:0]               head_word;
    logic [CW-1:0]                   fifo_count;
    logic                            fifo_full;
    logic                            fifo_empty;
    logic                            push;
    logic                            pop;
    logic [LANES-1:0][SAMP_W-1:0]    samples;

    // Accepts a word only when there is a free slot.
    always_comb begin
        push    = in_valid && !fifo_full;
        in_stop = (fifo_count >= CW'(DEPTH - STOP_ROOM));
    end

    word_fifo #(
        .WORD_W (WORD_W),
        .DEPTH  (DEPTH)
    ) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (push),
        .wr_data (in_data),
        .pop     (pop),
        .rd_data (head_word),
        .count   (fifo_count),
        .full    (fifo_full),
        .empty   (fifo_empty)
    );

    // One justification slice per lane of the head word.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        lane_justify #(
            .LANE_W (LANE_W),
            .SAMP_W (SAMP_W)
        ) u_just (
            .lane     (head_word[g*LANE_W +: LANE_W]),
            .left_sel (left_just),
            .sample   (samples[g])
        );
    end

    pair_sequencer #(
        .SAMP_W (SAMP_W),
        .PAIRS  (PAIRS)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .out_en     (out_en),
        .head_valid (!fifo_empty),
        .samples    (samples),
        .pop        (pop),
        .out_a      (out_a),
        .out_b      (out_b),
        .out_valid  (out_valid)
    );

    // With stop low last cycle, at most one more word can have landed.
    AST_STOP_HEADROOM: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(in_stop) |-> !fifo_full); // R9

    // Stop rises only after a word was accepted.
    AST_STOP_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $rose(in_stop) |-> $past(push)); // R8

endmodule

// File: tb/tb_tx_pair_unpacker.sv
`timescale 1ns/1ps
module tb_tx_pair_unpacker;

    localparam int DEPTH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        left_just = 1'b0;
    logic [63:0] in_data = '0;
    logic        in_valid = 1'b0;
    logic        in_stop;
    logic        out_en = 1'b0;
    logic [11:0] out_a;
    logic [11:0] out_b;
    logic        out_valid;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // Reference model state.
    logic [63:0] mq[$];
    int          m_phase = 0;
    logic [11:0] m_a = '0;
    logic [11:0] m_b = '0;
    logic        m_v = 1'b0;
    bit          late_ok_push = 1'b0;

    always #2 clk = ~clk;

    tx_pair_unpacker dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .left_just (left_just),
        .in_data   (in_data),
        .in_valid  (in_valid),
        .in_stop   (in_stop),
        .out_en    (out_en),
        .out_a     (out_a),
        .out_b     (out_b),
        .out_valid (out_valid)
    );

    function automatic logic [11:0] pick(input logic [63:0] w, input int lane, input logic lj);
        logic [15:0] l;
        l = w[lane*16 +: 16];
        return lj ? l[15:4] : l[11:0];   // R3 upper bits, R4 lower bits
    endfunction

    // Behavioural model, updated on each rising edge from the driven inputs.
    always @(posedge clk) begin
        if (!rst_n) begin
            mq.delete();
            m_phase = 0;
            m_a = '0; m_b = '0; m_v = 1'b0;
        end else begin
            int  sz;
            bit  was_full;
            sz = mq.size();
            was_full = (sz == DEPTH);
            if (late_ok_push && in_valid) begin
                n_cmp++;
                if (was_full) begin
                    n_bad++;
                    $display("FAIL R9 late-reacting source met a full buffer: actual full=1 expected full=0");
                end
            end
            if (out_en) begin
                if (sz > 0) begin
                    m_a = pick(mq[0], 2*m_phase, left_just);     // R2 A lane
                    m_b = pick(mq[0], 2*m_phase + 1, left_just); // R2 B lane
                    m_v = 1'b1;
                    if (m_phase == 1) begin
                        void'(mq.pop_front());
                        m_phase = 0;
                    end else begin
                        m_phase = 1;
                    end
                end else begin
                    m_v = 1'b0;   // R7
                end
            end
            if (in_valid && !was_full) mq.push_back(in_data); // R10 drop when full
        end
    end

    task automatic compare(input string tag);
        bit exp_stop;
        exp_stop = rst_n && (mq.size() >= DEPTH - 2);
        n_cmp++;
        if (in_stop !== exp_stop) begin
            n_bad++;
            $display("FAIL R8 %s in_stop actual=%0b expected=%0b", tag, in_stop, exp_stop);
        end
        n_cmp++;
        if (out_valid !== m_v) begin
            n_bad++;
            $display("FAIL R5/R7 %s out_valid actual=%0b expected=%0b", tag, out_valid, m_v);
        end
        n_cmp++;
        if (out_a !== m_a || out_b !== m_b) begin
            n_bad++;
            $display("FAIL R2/R3/R4 %s pair actual=%h/%h expected=%h/%h", tag, out_a, out_b, m_a, m_b);
        end
    endtask

    // One cycle: compare at the falling edge, then drive the next inputs.
    // mode 0: idle source, 1: source obeys stop one cycle late, 2: ignores stop.
    bit prev_stop = 1'b0;
    task automatic cycle(input string tag, input int mode, input bit en, input bit lj);
        @(negedge clk);
        compare(tag);
        out_en    = en;
        left_just = lj;
        in_data   = {$urandom(), $urandom()};
        case (mode)
            1: in_valid = !prev_stop && ($urandom_range(0, 3) != 0);
            2: in_valid = 1'b1;
            default: in_valid = 1'b0;
        endcase
        late_ok_push = (mode == 1);
        prev_stop = in_stop;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: state while reset is held
        compare("R1 reset");
        @(negedge clk);
        rst_n = 1'b1;
        // R1: first cycle after reset
        cycle("R1 post-reset", 0, 1'b0, 1'b0);
        // R2 R4 R11: right-justified stream, output always enabled
        for (int i = 0; i < 300; i++) cycle("R4 stream", 1, 1'b1, 1'b0);
        // R2 R3: left-justified stream with sparse output enable (R6)
        for (int i = 0; i < 300; i++) cycle("R3 R6 gated", 1, ($urandom_range(0, 1) == 1), 1'b1);
        // R10: output stalled while the source ignores stop
        for (int i = 0; i < 12; i++) cycle("R10 overrun", 2, 1'b0, 1'b0);
        // R7: drain to empty, then keep enabled with no input
        for (int i = 0; i < 20; i++) cycle("R7 drain", 0, 1'b1, 1'b0);
        // R4 R3: justification switched between the two pairs of a word
        for (int i = 0; i < 200; i++) cycle("R3 R4 toggle", 1, 1'b1, i[0]);
        // R5 R11: single words into an empty buffer
        for (int i = 0; i < 60; i++) cycle("R5 R11 single", (i % 6 == 0) ? 2 : 0, 1'b1, 1'b1);
        for (int i = 0; i < 4; i++) cycle("final", 0, 1'b1, 1'b0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog run did not finish: actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule